// File: doc/BRIEF.md
# Receive Buffer Chaining DMA Engine

This engine takes a received packet, delivered one byte per cycle with start and end marks, and places it into a chain of host buffers. It pops each buffer from a free queue. The queue index depends on where that buffer sits in the packet. The engine writes a small descriptor for every buffer it fills. When the packet has fully arrived, it writes a packet descriptor and pushes the packet's descriptor pointer to a completion queue.

A flow configuration sets the following for the whole packet:
- the descriptor mode: chained or single-buffer;
- a byte offset for the first buffer;
- the default completion queue;
- the tags and the packet type copied into the packet descriptor.

A valid queue override presented with the first byte of the packet replaces the default completion queue. In single-buffer mode, a packet longer than one buffer is cut into several packets. Each of those packets fills exactly one buffer, except that the last one holds whatever bytes remain.

The free-queue responder returns three values: the descriptor pointer, the buffer byte address and the buffer size. All memory writes leave through one port. Each write is either a single byte (packet data) or a 32-bit word (descriptor fields). Configuration must not change while a packet is in progress. Every buffer must be larger than the first-buffer offset. The packet type must be at most 6 bits wide and the length at most 16 bits.

Top module: `rx_chain_dma`

## Requirements
- R1: In chained mode, the free-queue index is set by the buffer's position in the packet: index 0 for the first buffer, 1 for the second, 2 for the third, and 3 for the fourth and every later buffer. `fq_req` and `fq_idx` stay unchanged until `fq_ack`.
- R2: Data bytes of the first buffer are written starting at the buffer address plus `cfg_sop_off`, and that buffer takes `fq_size - cfg_sop_off` bytes. Bytes go to consecutive addresses, one byte write per accepted input byte.
- R3: In chained mode, a new buffer is fetched only when the current buffer is full and the end mark has not yet arrived. Later buffers are filled from their start address up to their full size. An end mark on the last free byte of a buffer closes the packet without any further fetch.
- R4: In single-buffer mode, the packet is closed as soon as the first buffer is full. The remaining bytes form further packets, each fetched from index 0 with the offset applied and each pushed separately.
- R5: Every buffer except the first gets a descriptor of three words at its descriptor pointer: +8 the data address, +12 the byte count, +16 the next descriptor pointer. It is written right after the next buffer is fetched, or at end of packet with a next pointer of 0.
- R6: After the last data byte, the packet descriptor is written at the first buffer's descriptor pointer as five words in address order, +0 through +16:
  - +0: {2'b01 (host type) in [31:30], packet type in [29:24], total packet length in [15:0]};
  - +4: {source tag [31:16], destination tag [15:0]};
  - +8: first data address;
  - +12: first buffer byte count;
  - +16: second descriptor pointer, or 0 for a one-buffer packet.
- R7: After each packet descriptor, a one-cycle `cq_push` carries the first descriptor pointer. The queue is `in_qovr` if `in_qovr_valid` was high with the start-of-packet byte, and `cfg_dest_q` otherwise.
- R8: `in_ready` is low after reset, low while a free-descriptor fetch is outstanding, and low while descriptors are being written. `cq_push` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_single | input | 1 | 0 chained buffers, 1 one buffer per packet |
| cfg_sop_off | input | LW | Byte offset into the first buffer |
| cfg_dest_q | input | QW | Default completion queue |
| cfg_src_tag | input | TW | Source tag for the packet descriptor |
| cfg_dst_tag | input | TW | Destination tag for the packet descriptor |
| cfg_pkt_type | input | PTW | Packet type for the packet descriptor |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_qovr_valid | input | 1 | Completion queue override present (taken with the first byte) |
| in_qovr | input | QW | Override queue number |
| fq_req | output | 1 | Free descriptor pop request |
| fq_idx | output | 2 | Free queue index to pop from |
| fq_ack | input | 1 | Pop response valid |
| fq_desc | input | AW | Popped descriptor pointer |
| fq_buf | input | AW | Buffer byte address |
| fq_size | input | LW | Buffer size in bytes |
| mem_we | output | 1 | Memory write strobe |
| mem_word | output | 1 | 1 for a 32-bit word write, 0 for a byte write |
| mem_addr | output | AW | Write byte address |
| mem_wdata | output | 32 | Write data (byte in [7:0] for byte writes) |
| cq_push | output | 1 | Completion queue push |
| cq_qnum | output | QW | Completion queue number |
| cq_ptr | output | AW | Completed packet descriptor pointer |

## Verification
The bench runs packets through the engine and compares every memory write, every pop index and every push against a model built from the requirements. The packets are chosen to separate distinct behaviours:
- One that fits a single buffer exercises the packet descriptor with a zero next pointer.
- A five-buffer packet with an offset walks the pop index through 0, 1, 2, 3, 3 and the delayed buffer-descriptor writes.
- Packets whose end mark falls exactly on a buffer boundary, one for the first buffer and one for a later buffer, show that no extra fetch happens.
- In single-buffer mode, a long packet splits into offset one-buffer packets, while a packet that exactly fills one buffer does not split.
- Overridden and default completion queues appear on different runs.

// File: rtl/rx_chain_dma.sv
module rx_chain_dma #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int QW  = 8,
  parameter int TW  = 16,
  parameter int PTW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_single,
  input  logic [LW-1:0]  cfg_sop_off,
  input  logic [QW-1:0]  cfg_dest_q,
  input  logic [TW-1:0]  cfg_src_tag,
  input  logic [TW-1:0]  cfg_dst_tag,
  input  logic [PTW-1:0] cfg_pkt_type,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic           in_qovr_valid,
  input  logic [QW-1:0]  in_qovr,
  output logic           fq_req,
  output logic [1:0]     fq_idx,
  input  logic           fq_ack,
  input  logic [AW-1:0]  fq_desc,
  input  logic [AW-1:0]  fq_buf,
  input  logic [LW-1:0]  fq_size,
  output logic           mem_we,
  output logic           mem_word,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic           cq_push,
  output logic [QW-1:0]  cq_qnum,
  output logic [AW-1:0]  cq_ptr
);
  localparam logic [1:0] LAST_IDX = 2'd3;
  localparam logic [2:0] BD_FIRST = 3'd2;
  localparam logic [2:0] W_LAST   = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FILL, S_BDW, S_PDW, S_PUSH} st_t;

  st_t           st;
  logic [1:0]    bidx;
  logic [2:0]    wc;
  logic          closing, more, ovr_v;
  logic [QW-1:0] ovr_q;
  logic [AW-1:0] cur_desc, cur_base, wptr;
  logic [AW-1:0] d_desc, d_addr, d_next;
  logic [AW-1:0] f_desc, f_addr, f_next;
  logic [LW-1:0] cur_len, room, d_len, f_len, pkt_len;
  logic [31:0]   bd_word, pd_word;
  logic          take, stop;

  assign in_ready = (st == S_FILL);
  assign take     = in_valid && in_ready;
  assign stop     = in_eop || (room == LW'(1));
  assign fq_req   = (st == S_FETCH);
  assign fq_idx   = bidx;
  assign cq_push  = (st == S_PUSH);
  assign cq_ptr   = f_desc;
  assign cq_qnum  = ovr_v ? ovr_q : cfg_dest_q;

  always_comb begin
    case (wc)
      3'd2:    bd_word = 32'(d_addr);
      3'd3:    bd_word = 32'(d_len);
      default: bd_word = 32'(d_next);
    endcase
    case (wc)
      3'd0:    pd_word = (32'(2'b01) << 30) | (32'(cfg_pkt_type) << 24) | 32'(pkt_len);
      3'd1:    pd_word = (32'(cfg_src_tag) << 16) | 32'(cfg_dst_tag);
      3'd2:    pd_word = 32'(f_addr);
      3'd3:    pd_word = 32'(f_len);
      default: pd_word = 32'(f_next);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bidx <= '0;
      wc <= '0;
      closing <= 1'b0;
      more <= 1'b0;
      ovr_v <= 1'b0;
      ovr_q <= '0;
      cur_desc <= '0;
      cur_base <= '0;
      wptr <= '0;
      d_desc <= '0;
      d_addr <= '0;
      d_next <= '0;
      f_desc <= '0;
      f_addr <= '0;
      f_next <= '0;
      cur_len <= '0;
      room <= '0;
      d_len <= '0;
      f_len <= '0;
      pkt_len <= '0;
      mem_we <= 1'b0;
      mem_word <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        S_IDLE: if (in_valid && in_sop) begin
          ovr_v <= in_qovr_valid;
          ovr_q <= in_qovr;
          pkt_len <= '0;
          bidx <= '0;
          st <= S_FETCH;
        end
        S_FETCH: if (fq_ack) begin
          d_desc <= cur_desc;
          d_addr <= cur_base;
          d_len <= cur_len;
          d_next <= fq_desc;
          cur_desc <= fq_desc;
          cur_len <= '0;
          if (bidx == 2'd0) begin
            cur_base <= fq_buf + AW'(cfg_sop_off);
            wptr <= fq_buf + AW'(cfg_sop_off);
            room <= fq_size - cfg_sop_off;
            f_desc <= fq_desc;
            f_addr <= fq_buf + AW'(cfg_sop_off);
            f_next <= '0;
            st <= S_FILL;
          end else begin
            cur_base <= fq_buf;
            wptr <= fq_buf;
            room <= fq_size;
            if (bidx == 2'd1) begin
              f_next <= fq_desc;
              st <= S_FILL;
            end else begin
              closing <= 1'b0;
              wc <= BD_FIRST;
              st <= S_BDW;
            end
          end
        end
        S_FILL: if (take) begin
          mem_we <= 1'b1;
          mem_word <= 1'b0;
          mem_addr <= wptr;
          mem_wdata <= {24'h0, in_data};
          wptr <= wptr + AW'(1);
          cur_len <= cur_len + LW'(1);
          pkt_len <= pkt_len + LW'(1);
          room <= room - LW'(1);
          if (stop) begin
            if (bidx == 2'd0) f_len <= cur_len + LW'(1);
            if (in_eop || cfg_single) begin
              more <= !in_eop;
              if (bidx == 2'd0) begin
                wc <= '0;
                st <= S_PDW;
              end else begin
                d_desc <= cur_desc;
                d_addr <= cur_base;
                d_len <= cur_len + LW'(1);
                d_next <= '0;
                closing <= 1'b1;
                wc <= BD_FIRST;
                st <= S_BDW;
              end
            end else begin
              bidx <= (bidx == LAST_IDX) ? bidx : bidx + 2'd1;
              st <= S_FETCH;
            end
          end
        end
        S_BDW: begin
          mem_we <= 1'b1;
          mem_word <= 1'b1;
          mem_addr <= d_desc + AW'({wc, 2'b00});
          mem_wdata <= bd_word;
          if (wc == W_LAST) begin
            wc <= '0;
            st <= closing ? S_PDW : S_FILL;
          end else begin
            wc <= wc + 3'd1;
          end
        end
        S_PDW: begin
          mem_we <= 1'b1;
          mem_word <= 1'b1;
          mem_addr <= f_desc + AW'({wc, 2'b00});
          mem_wdata <= pd_word;
          if (wc == W_LAST) st <= S_PUSH;
          else wc <= wc + 3'd1;
        end
        S_PUSH: begin
          pkt_len <= '0;
          bidx <= '0;
          closing <= 1'b0;
          more <= 1'b0;
          st <= more ? S_FETCH : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  fq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_req && !fq_ack |=> fq_req && $stable(fq_idx));

  // R4
  single_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_req && cfg_single |-> fq_idx == 2'd0);

  // R2
  room_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> room != '0);

  // R7
  push_after_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_push |-> mem_we && mem_word && mem_addr == cq_ptr + AW'(16));

  // R8
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cq_push |=> !cq_push);
endmodule

// File: tb/rx_chain_dma_test.sv
module rx_chain_dma_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_single = 1'b0;
  logic [15:0] cfg_sop_off = '0;
  logic [7:0]  cfg_dest_q = 8'h0A;
  logic [15:0] cfg_src_tag = 16'h1111, cfg_dst_tag = 16'h2222;
  logic [5:0]  cfg_pkt_type = 6'h05;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_qovr_valid = 1'b0;
  logic [7:0]  in_data = '0, in_qovr = '0;
  logic        in_ready;
  logic        fq_req, fq_ack = 1'b0;
  logic [1:0]  fq_idx;
  logic [31:0] fq_desc = '0, fq_buf = '0;
  logic [15:0] fq_size = '0;
  logic        mem_we, mem_word, cq_push;
  logic [31:0] mem_addr, mem_wdata, cq_ptr;
  logic [7:0]  cq_qnum;

  rx_chain_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_sop_off(cfg_sop_off),
    .cfg_dest_q(cfg_dest_q), .cfg_src_tag(cfg_src_tag), .cfg_dst_tag(cfg_dst_tag),
    .cfg_pkt_type(cfg_pkt_type), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_qovr_valid(in_qovr_valid),
    .in_qovr(in_qovr), .fq_req(fq_req), .fq_idx(fq_idx), .fq_ack(fq_ack),
    .fq_desc(fq_desc), .fq_buf(fq_buf), .fq_size(fq_size), .mem_we(mem_we),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cq_push(cq_push), .cq_qnum(cq_qnum), .cq_ptr(cq_ptr));

  typedef struct { logic word; logic [31:0] addr; logic [31:0] data; string tag; } wr_t;
  typedef struct { logic [7:0] q; logic [31:0] ptr; } push_t;
  typedef struct { logic [1:0] idx; string tag; } pop_t;
  wr_t   exp_w[$];
  push_t exp_p[$];
  pop_t  exp_f[$];

  int checks = 0, fails = 0;
  int sz[4] = '{16, 8, 8, 8};
  int mcnt[4] = '{0, 0, 0, 0};
  int rcnt[4] = '{0, 0, 0, 0};
  int rdly = 0;

  function automatic logic [31:0] desc_of(int i, int n);
    return 32'h1000 + 32'(i) * 32'h1000 + 32'(n) * 32'h40;
  endfunction
  function automatic logic [31:0] buf_of(int i, int n);
    return 32'h10_0000 + 32'(i) * 32'h10_0000 + 32'(n) * 32'h400;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put_w(logic word, logic [31:0] a, logic [31:0] d, string tag);
    wr_t e;
    e.word = word; e.addr = a; e.data = d; e.tag = tag;
    exp_w.push_back(e);
  endtask

  task automatic put_f(int idx, string tag);
    pop_t e;
    e.idx = 2'(idx); e.tag = tag;
    exp_f.push_back(e);
  endtask

  task automatic put_bd(logic [31:0] d, logic [31:0] a, int n, logic [31:0] nx);
    put_w(1'b1, d + 32'd8, a, "R5");
    put_w(1'b1, d + 32'd12, 32'(n), "R5");
    put_w(1'b1, d + 32'd16, nx, "R5");
  endtask

  task automatic gen_expect(int len, bit mode, int off, int seed, bit ov, logic [7:0] oq);
    int rem, pos, pc, plen, room, n, clen, flen, idx;
    logic [31:0] d, b, fdesc, faddr, fnext, cdesc, base;
    push_t pe;
    rem = len; pos = 0;
    while (rem > 0) begin
      pc = 0; plen = 0;
      put_f(0, mode ? "R4" : "R1");
      d = desc_of(0, mcnt[0]); b = buf_of(0, mcnt[0]); mcnt[0]++;
      fdesc = d; faddr = b + 32'(off); fnext = '0; cdesc = d; base = faddr;
      room = sz[0] - off; flen = 0;
      while (1) begin
        n = (room < rem) ? room : rem;
        for (int k = 0; k < n; k++)
          put_w(1'b0, base + 32'(k), 32'((seed + pos + k) & 8'hFF), pc == 0 ? "R2" : "R3");
        pos += n; rem -= n; plen += n; clen = n;
        if (pc == 0) flen = clen;
        if (rem == 0 || mode) begin
          if (pc != 0) put_bd(cdesc, base, clen, '0);
          put_w(1'b1, fdesc, {2'b01, cfg_pkt_type, 8'h00, 16'(plen)}, "R6");
          put_w(1'b1, fdesc + 32'd4, {cfg_src_tag, cfg_dst_tag}, "R6");
          put_w(1'b1, fdesc + 32'd8, faddr, "R6");
          put_w(1'b1, fdesc + 32'd12, 32'(flen), "R6");
          put_w(1'b1, fdesc + 32'd16, fnext, "R6");
          pe.q = ov ? oq : cfg_dest_q; pe.ptr = fdesc;
          exp_p.push_back(pe);
          break;
        end
        pc++;
        idx = (pc > 3) ? 3 : pc;
        put_f(idx, "R1");
        d = desc_of(idx, mcnt[idx]); b = buf_of(idx, mcnt[idx]); mcnt[idx]++;
        if (pc == 1) fnext = d;
        else put_bd(cdesc, base, clen, d);
        cdesc = d; base = b; room = sz[idx];
      end
    end
  endtask

  task automatic send(int len, bit mode, int off, int seed, bit ov, logic [7:0] oq, string tag);
    cfg_single = mode; cfg_sop_off = 16'(off);
    gen_expect(len, mode, off, seed, ov, oq);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1; in_data = 8'((seed + k) & 8'hFF);
      in_sop = (k == 0); in_eop = (k == len - 1);
      in_qovr_valid = ov; in_qovr = oq;
      while (1) begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    while (exp_w.size() != 0 || exp_p.size() != 0 || exp_f.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R3: no extra fetch once the packet has closed
    check(!fq_req, tag, "idle fq_req", 32'(fq_req), 0);
    check(!in_ready, "R8", "idle in_ready", 32'(in_ready), 0);
  endtask

  // free-queue responder
  always @(negedge clk) begin
    if (fq_ack) fq_ack = 1'b0;
    else if (fq_req) begin
      if (rdly == 1) begin
        pop_t e;
        rdly = 0;
        if (exp_f.size() == 0) check(1'b0, "R3", "unexpected fetch idx", 32'(fq_idx), 0);
        else begin
          e = exp_f.pop_front();
          check(fq_idx == e.idx, e.tag, "fetch idx", 32'(fq_idx), 32'(e.idx));
        end
        fq_desc = desc_of(int'(fq_idx), rcnt[fq_idx]);
        fq_buf  = buf_of(int'(fq_idx), rcnt[fq_idx]);
        fq_size = 16'(sz[fq_idx]);
        rcnt[fq_idx]++;
        fq_ack = 1'b1;
      end else rdly++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (fq_req) check(!in_ready, "R8", "ready during fetch", 32'(in_ready), 0);
      if (mem_we) begin
        wr_t e;
        if (exp_w.size() == 0) check(1'b0, "R6", "unexpected write", mem_addr, 0);
        else begin
          e = exp_w.pop_front();
          check(mem_word == e.word && mem_addr == e.addr, e.tag, "write addr", mem_addr, e.addr);
          check(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
        end
      end
      if (cq_push) begin
        push_t p;
        if (exp_p.size() == 0) check(1'b0, "R7", "unexpected push", cq_ptr, 0);
        else begin
          p = exp_p.pop_front();
          check(cq_ptr == p.ptr, "R7", "push ptr", cq_ptr, p.ptr);
          check(cq_qnum == p.q, "R7", "push queue", 32'(cq_qnum), 32'(p.q));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready, "R8", "reset in_ready", 32'(in_ready), 0);
    check(!fq_req, "R8", "reset fq_req", 32'(fq_req), 0);
    check(!mem_we, "R8", "reset mem_we", 32'(mem_we), 0);
    check(!cq_push, "R8", "reset cq_push", 32'(cq_push), 0);
    send(5, 1'b0, 0, 8'h10, 1'b0, 8'h00, "R3");   // one buffer, default queue
    send(39, 1'b0, 4, 8'h40, 1'b0, 8'h00, "R1");  // five buffers: 0,1,2,3,3
    cfg_src_tag = 16'hABCD; cfg_dst_tag = 16'h0F0F; cfg_pkt_type = 6'h2A;
    send(12, 1'b0, 4, 8'h80, 1'b1, 8'h55, "R3");  // ends exactly on first buffer
    send(24, 1'b0, 0, 8'hC0, 1'b0, 8'h00, "R3");  // ends exactly on second buffer
    send(35, 1'b1, 2, 8'h20, 1'b1, 8'h21, "R4");  // split 14,14,7
    send(14, 1'b1, 2, 8'h70, 1'b0, 8'h00, "R4");  // fills one buffer exactly
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule